// File: doc/BRIEF.md
# Link Speed Bring-Up Sequencer

This block runs the start-up of a serial link that can operate at a base rate (2.5 GT/s) or a doubled rate (5.0 GT/s). A start pulse first pins the advertised speed cap to the base rate, and only then turns on link training. The block then waits for the link to come up. If the configured top generation is 2, it raises the cap to the doubled rate, requests a directed speed change and waits for the change to settle. It then waits for link-up a second time and latches the negotiated speed. If the top generation is anything else, it stops at the base rate and flags that promotion was skipped.

The end of a directed change is found in one of two ways. In self-clearing mode the request bit is polled until the link reports it clear, with a bounded number of attempts. In the other mode the poll is skipped and the block goes straight to the second link-up wait. Any failure, whether a link-up timeout or a poll timeout, triggers a receiver reset: both receive overrides (data enable and PLL enable) are held high for a fixed number of cycles, then released, and the failure flag is raised. Busy, done and fail hold until the next start.

The FSM states are IDLE, CAP, TRAIN1, PROMOTE, POLL, TRAIN2, RXRST, DONE and FAIL. The transitions are:
- IDLE, DONE or FAIL go to CAP when start is seen.
- CAP goes to TRAIN1 after one cycle.
- TRAIN1 goes to PROMOTE on link-up when the top generation is 2, and to DONE on link-up otherwise. It goes to RXRST on timeout.
- PROMOTE goes to POLL in self-clearing mode and to TRAIN2 otherwise.
- POLL goes to TRAIN2 when a poll reads clear, and to RXRST when the last attempt still reads busy.
- TRAIN2 goes to DONE on link-up and to RXRST on timeout.
- RXRST goes to FAIL when the hold expires.

Top module: `lnk_rate_seq`

## Requirements
- R1: After reset the block is idle. `speed_cap_o` holds the base code 1, and `train_en_o`, `spd_chg_req_o`, both override outputs, `busy_o`, `done_o`, `fail_o` and `gen2_off_o` are 0. `final_speed_o` is 0.
- R2: In the cycle after start is accepted, `speed_cap_o` is 1 (2.5 GT/s) and `train_en_o` is 0. `train_en_o` rises in the following cycle. `busy_o` is 1 and `done_o`/`fail_o` are 0 from the accepted start on.
- R3: When `max_gen_i` is not 2, the first link-up ends the run. `done_o` and `gen2_off_o` are 1, `speed_cap_o` stays 1 and `spd_chg_req_o` never rises.
- R4: When `max_gen_i` is 2, the first link-up rewrites `speed_cap_o` to code 2 (5.0 GT/s) and asserts `spd_chg_req_o`.
- R5: In self-clearing mode (`sc_self_clear_i`=1), `spd_chg_busy_i` is sampled once every POLL_GAP cycles. The first sample that reads 0 drops the request and starts the second link-up wait. If POLL_MAX consecutive samples read 1, the run fails. The request is then high for exactly 1+POLL_MAX*POLL_GAP cycles.
- R6: In skip mode (`sc_self_clear_i`=0), `spd_chg_req_o` is high for a single cycle and the block moves directly to the second link-up wait.
- R7: After the speed change, success is declared only on a fresh link-up. Then `done_o`=1, `gen2_off_o`=0, and `final_speed_o` latches `cur_speed_i`. On failure `final_speed_o` stays 0.
- R8: Each link-up wait lasts at most `link_tmo_i` cycles. When it expires, the failure path starts, and `fail_o` rises exactly `link_tmo_i`+HOLD_CYC cycles after training was enabled.
- R9: On failure, both receive overrides are high together for exactly HOLD_CYC cycles with `train_en_o` low. They are then released, and `fail_o` rises at the same time.
- R10: `done_o` and `fail_o` hold until the next start. A start seen while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Launch pulse |
| max_gen_i | input | GEN_W | Configured top generation (2 enables promotion) |
| sc_self_clear_i | input | 1 | 1: poll for speed-change completion; 0: skip the poll |
| link_tmo_i | input | TMO_W | Link-up wait limit in cycles |
| link_up_i | input | 1 | Link-up status from the training logic |
| spd_chg_busy_i | input | 1 | Read-back of the speed-change bit |
| cur_speed_i | input | SPD_W | Current negotiated link speed code |
| speed_cap_o | output | SPD_W | Advertised speed cap (1 = 2.5 GT/s, 2 = 5.0 GT/s) |
| train_en_o | output | 1 | Link training enable |
| spd_chg_req_o | output | 1 | Directed speed-change request bit |
| rx_data_en_ovr_o | output | 1 | Receive-data-enable override to the PHY |
| rx_pll_en_ovr_o | output | 1 | Receive-PLL-enable override to the PHY |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence succeeded |
| fail_o | output | 1 | Sequence failed |
| gen2_off_o | output | 1 | Success at base rate, promotion skipped |
| final_speed_o | output | SPD_W | Speed latched on success |

## Verification
The hardest situation to reach is the poll timeout. The run has to pass the first link-up with promotion enabled and in self-clearing mode, and then see the busy read-back held high for all POLL_MAX samples. The stimulus gets there by holding link-up high before start and tying the busy read-back high for the whole run. It then counts the request-high cycles and the override-high cycles exactly. A second hard case is a start pulse in the middle of a run: the bench injects it during the first wait and confirms that training never drops and the run finishes as if no pulse had come.

// File: rtl/lrs_pkg.sv
package lrs_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CAP,
        S_TRAIN1,
        S_PROMOTE,
        S_POLL,
        S_TRAIN2,
        S_RXRST,
        S_DONE,
        S_FAIL
    } lrs_state_e;

    // speed-cap encodings
    localparam int LRS_SPD_BASE = 1;   // 2.5 GT/s
    localparam int LRS_SPD_GEN2 = 2;   // 5.0 GT/s
    localparam int LRS_PROMO_GEN = 2;  // top generation that enables promotion

endpackage

// File: rtl/lrs_cycle_timer.sv
// Counts cycles while run_i is high; expired_o flags the limit-th cycle and
// the count restarts, so a held run_i gives a periodic tick.
module lrs_cycle_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_i,
    input  logic [W-1:0] limit_i,
    output logic         expired_o
);

    logic [W-1:0] cnt_q;
    logic [W:0]   cnt_inc;

    assign cnt_inc   = {1'b0, cnt_q} + {{W{1'b0}}, 1'b1};
    assign expired_o = run_i && (cnt_inc >= {1'b0, limit_i});

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i || expired_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_inc[W-1:0];
        end
    end

endmodule

// File: rtl/lrs_attempt_ctr.sv
// Counts failed poll attempts; last_o marks that the next failed attempt is
// the final one allowed.
module lrs_attempt_ctr #(
    parameter int MAX = 200,
    parameter int W   = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic inc_i,
    output logic last_o
);

    logic [W-1:0] cnt_q;

    assign last_o = (cnt_q == W'(MAX - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (inc_i && !last_o) begin
            cnt_q <= cnt_q + W'(1);
        end
    end

endmodule

// File: rtl/lnk_rate_seq.sv
module lnk_rate_seq
    import lrs_pkg::*;
#(
    parameter int SPD_W    = 4,
    parameter int GEN_W    = 2,
    parameter int TMO_W    = 16,
    parameter int POLL_MAX = 200,
    parameter int POLL_GAP = 4,
    parameter int HOLD_CYC = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [GEN_W-1:0] max_gen_i,
    input  logic             sc_self_clear_i,
    input  logic [TMO_W-1:0] link_tmo_i,
    input  logic             link_up_i,
    input  logic             spd_chg_busy_i,
    input  logic [SPD_W-1:0] cur_speed_i,
    output logic [SPD_W-1:0] speed_cap_o,
    output logic             train_en_o,
    output logic             spd_chg_req_o,
    output logic             rx_data_en_ovr_o,
    output logic             rx_pll_en_ovr_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             fail_o,
    output logic             gen2_off_o,
    output logic [SPD_W-1:0] final_speed_o
);

    localparam int PM_W   = $clog2(POLL_MAX + 1);
    localparam int GAP_W  = $clog2(POLL_GAP + 1);
    localparam int HOLD_W = $clog2(HOLD_CYC + 1);

    localparam logic [SPD_W-1:0] CAP_BASE  = SPD_W'(LRS_SPD_BASE);
    localparam logic [SPD_W-1:0] CAP_GEN2  = SPD_W'(LRS_SPD_GEN2);
    localparam logic [GEN_W-1:0] GEN_PROMO = GEN_W'(LRS_PROMO_GEN);

    lrs_state_e state_q, state_d;

    logic link_wait, link_tmo_hit;
    logic poll_run, poll_tick, poll_last;
    logic hold_run, hold_hit;
    logic start_ok, promo_en;

    logic [SPD_W-1:0] cap_q;
    logic [SPD_W-1:0] final_q;
    logic             gen2_off_q;

    assign start_ok  = start_i && (state_q == S_IDLE || state_q == S_DONE
                                   || state_q == S_FAIL);
    assign promo_en  = (max_gen_i == GEN_PROMO);
    assign link_wait = (state_q == S_TRAIN1) || (state_q == S_TRAIN2);
    assign poll_run  = (state_q == S_POLL);
    assign hold_run  = (state_q == S_RXRST);

    // ---------------- timers ----------------
    lrs_cycle_timer #(.W(TMO_W)) u_link_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (link_wait),
        .limit_i   (link_tmo_i),
        .expired_o (link_tmo_hit)
    );

    lrs_cycle_timer #(.W(GAP_W)) u_gap_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (poll_run),
        .limit_i   (GAP_W'(POLL_GAP)),
        .expired_o (poll_tick)
    );

    lrs_cycle_timer #(.W(HOLD_W)) u_hold_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (hold_run),
        .limit_i   (HOLD_W'(HOLD_CYC)),
        .expired_o (hold_hit)
    );

    lrs_attempt_ctr #(.MAX(POLL_MAX), .W(PM_W)) u_attempts (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (!poll_run),
        .inc_i  (poll_tick && spd_chg_busy_i),
        .last_o (poll_last)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE, S_DONE, S_FAIL: begin
                if (start_i) state_d = S_CAP;
            end
            S_CAP: begin
                state_d = S_TRAIN1;
            end
            S_TRAIN1: begin
                if (link_up_i) begin
                    state_d = promo_en ? S_PROMOTE : S_DONE;
                end else if (link_tmo_hit) begin
                    state_d = S_RXRST;
                end
            end
            S_PROMOTE: begin
                state_d = sc_self_clear_i ? S_POLL : S_TRAIN2;
            end
            S_POLL: begin
                if (poll_tick) begin
                    if (!spd_chg_busy_i) begin
                        state_d = S_TRAIN2;
                    end else if (poll_last) begin
                        state_d = S_RXRST;
                    end
                end
            end
            S_TRAIN2: begin
                if (link_up_i) begin
                    state_d = S_DONE;
                end else if (link_tmo_hit) begin
                    state_d = S_RXRST;
                end
            end
            S_RXRST: begin
                if (hold_hit) state_d = S_FAIL;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // ---------------- registered results ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q      <= CAP_BASE;
            final_q    <= '0;
            gen2_off_q <= 1'b0;
        end else if (start_ok) begin
            cap_q      <= CAP_BASE;
            final_q    <= '0;
            gen2_off_q <= 1'b0;
        end else if (state_q == S_TRAIN1 && link_up_i) begin
            if (promo_en) begin
                cap_q <= CAP_GEN2;
            end else begin
                final_q    <= cur_speed_i;
                gen2_off_q <= 1'b1;
            end
        end else if (state_q == S_TRAIN2 && link_up_i) begin
            final_q <= cur_speed_i;
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        train_en_o       = 1'b0;
        spd_chg_req_o    = 1'b0;
        rx_data_en_ovr_o = 1'b0;
        rx_pll_en_ovr_o  = 1'b0;
        busy_o           = 1'b0;
        done_o           = 1'b0;
        fail_o           = 1'b0;
        unique case (state_q)
            S_IDLE: ;
            S_CAP: busy_o = 1'b1;
            S_TRAIN1, S_TRAIN2: begin
                busy_o     = 1'b1;
                train_en_o = 1'b1;
            end
            S_PROMOTE, S_POLL: begin
                busy_o        = 1'b1;
                train_en_o    = 1'b1;
                spd_chg_req_o = 1'b1;
            end
            S_RXRST: begin
                busy_o           = 1'b1;
                rx_data_en_ovr_o = 1'b1;
                rx_pll_en_ovr_o  = 1'b1;
            end
            S_DONE: begin
                done_o     = 1'b1;
                train_en_o = 1'b1;
            end
            S_FAIL: fail_o = 1'b1;
            default: ;
        endcase
    end

    assign speed_cap_o   = cap_q;
    assign final_speed_o = final_q;
    assign gen2_off_o    = gen2_off_q;

endmodule

// File: rtl/lrs_checker.sv
module lrs_checker
    import lrs_pkg::*;
#(
    parameter int SPD_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [SPD_W-1:0] speed_cap_o,
    input logic             train_en_o,
    input logic             spd_chg_req_o,
    input logic             rx_data_en_ovr_o,
    input logic             rx_pll_en_ovr_o,
    input logic             busy_o,
    input logic             done_o,
    input logic             fail_o,
    input logic             gen2_off_o
);

    // R2: training only starts once the base cap is applied
    a_r2_cap_before_train: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(train_en_o) |-> (speed_cap_o == SPD_W'(LRS_SPD_BASE)) && $past(busy_o));

    // R4: a speed-change request only with the doubled-rate cap
    a_r4_req_with_gen2_cap: assert property (@(posedge clk) disable iff (!rst_n)
        spd_chg_req_o |-> (speed_cap_o == SPD_W'(LRS_SPD_GEN2)));

    // R3: promotion-skipped flag only on a base-rate success
    a_r3_gen2_off_base: assert property (@(posedge clk) disable iff (!rst_n)
        gen2_off_o |-> done_o && (speed_cap_o == SPD_W'(LRS_SPD_BASE)));

    // R9: overrides move together, keep training off, release into fail
    a_r9_ovr_pair: assert property (@(posedge clk) disable iff (!rst_n)
        rx_data_en_ovr_o |-> rx_pll_en_ovr_o && !train_en_o);
    a_r9_release_to_fail: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_pll_en_ovr_o) |-> fail_o);

    // R10: status flags are exclusive and hold until a start
    a_r10_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && fail_o) && !(busy_o && (done_o || fail_o)));
    a_r10_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o);
    a_r10_fail_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_o && !start_i) |=> fail_o);

endmodule

bind lnk_rate_seq lrs_checker #(.SPD_W(SPD_W)) u_lrs_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .start_i          (start_i),
    .speed_cap_o      (speed_cap_o),
    .train_en_o       (train_en_o),
    .spd_chg_req_o    (spd_chg_req_o),
    .rx_data_en_ovr_o (rx_data_en_ovr_o),
    .rx_pll_en_ovr_o  (rx_pll_en_ovr_o),
    .busy_o           (busy_o),
    .done_o           (done_o),
    .fail_o           (fail_o),
    .gen2_off_o       (gen2_off_o)
);

// File: tb/tb_lnk_rate_seq.sv
module tb_lnk_rate_seq;

    localparam int SPD_W    = 4;
    localparam int GEN_W    = 2;
    localparam int TMO_W    = 16;
    localparam int POLL_MAX = 200;
    localparam int POLL_GAP = 4;
    localparam int HOLD_CYC = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [GEN_W-1:0] max_gen_i = '0;
    logic             sc_self_clear_i = 1'b0;
    logic [TMO_W-1:0] link_tmo_i = TMO_W'(1000);
    logic             link_up_i = 1'b0;
    logic             spd_chg_busy_i = 1'b0;
    logic [SPD_W-1:0] cur_speed_i = '0;
    logic [SPD_W-1:0] speed_cap_o;
    logic             train_en_o, spd_chg_req_o;
    logic             rx_data_en_ovr_o, rx_pll_en_ovr_o;
    logic             busy_o, done_o, fail_o, gen2_off_o;
    logic [SPD_W-1:0] final_speed_o;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    lnk_rate_seq #(
        .SPD_W(SPD_W), .GEN_W(GEN_W), .TMO_W(TMO_W),
        .POLL_MAX(POLL_MAX), .POLL_GAP(POLL_GAP), .HOLD_CYC(HOLD_CYC)
    ) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .max_gen_i(max_gen_i),
        .sc_self_clear_i(sc_self_clear_i), .link_tmo_i(link_tmo_i),
        .link_up_i(link_up_i), .spd_chg_busy_i(spd_chg_busy_i),
        .cur_speed_i(cur_speed_i), .speed_cap_o(speed_cap_o),
        .train_en_o(train_en_o), .spd_chg_req_o(spd_chg_req_o),
        .rx_data_en_ovr_o(rx_data_en_ovr_o), .rx_pll_en_ovr_o(rx_pll_en_ovr_o),
        .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o),
        .gen2_off_o(gen2_off_o), .final_speed_o(final_speed_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    // start pulse plus the R2 checks on the two following cycles
    task automatic do_start();
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        chk("R2 cap before training", int'(speed_cap_o), 1);
        chk("R2 training off in cap cycle", int'(train_en_o), 0);
        chk("R10 busy after start", int'(busy_o), 1);
        chk("R10 flags cleared by start", int'(done_o | fail_o), 0);
        @(negedge clk);
        chk("R2 training on", int'(train_en_o), 1);
    endtask

    task automatic run_until_end(output int cyc, output int req_n, output int ovr_n,
                                 output int bad_train);
        cyc = 0; req_n = 0; ovr_n = 0; bad_train = 0;
        while (!(done_o || fail_o) && cyc < 5000) begin
            @(negedge clk);
            cyc++;
            if (spd_chg_req_o) req_n++;
            if (rx_data_en_ovr_o && rx_pll_en_ovr_o) begin
                ovr_n++;
                if (train_en_o) bad_train++;
            end
        end
    endtask

    task automatic t_reset();
        chk("R1 idle busy", int'(busy_o), 0);
        chk("R1 idle flags", int'(done_o | fail_o | gen2_off_o), 0);
        chk("R1 idle training", int'(train_en_o | spd_chg_req_o), 0);
        chk("R1 idle overrides", int'(rx_data_en_ovr_o | rx_pll_en_ovr_o), 0);
        chk("R1 idle cap", int'(speed_cap_o), 1);
        chk("R1 idle final speed", int'(final_speed_o), 0);
    endtask

    task automatic t_base_rate();
        int cyc, rq, ov, bt;
        max_gen_i = 2'd1; link_up_i = 1'b0; cur_speed_i = 4'd1;
        link_tmo_i = TMO_W'(1000);
        do_start();
        repeat (5) @(negedge clk);
        link_up_i = 1'b1;
        run_until_end(cyc, rq, ov, bt);
        chk("R3 done at base rate", int'(done_o), 1);
        chk("R3 promotion skipped flag", int'(gen2_off_o), 1);
        chk("R3 cap stays base", int'(speed_cap_o), 1);
        chk("R3 no speed-change request", rq, 0);
        chk("R7 final speed latched base", int'(final_speed_o), 1);
        repeat (10) @(negedge clk);
        chk("R10 done held", int'(done_o), 1);
        chk("R10 not busy when done", int'(busy_o), 0);
        link_up_i = 1'b0;
    endtask

    task automatic t_self_clear();
        int cyc, rq, ov, bt, k, still;
        max_gen_i = 2'd2; sc_self_clear_i = 1'b1; link_up_i = 1'b1;
        spd_chg_busy_i = 1'b1; cur_speed_i = 4'd1;
        do_start();
        k = 0;
        while (!spd_chg_req_o && k < 10) begin
            @(negedge clk);
            k++;
        end
        chk("R4 request raised", int'(spd_chg_req_o), 1);
        chk("R4 cap raised to gen2", int'(speed_cap_o), 2);
        link_up_i = 1'b0;
        still = 0;
        repeat (20) begin
            @(negedge clk);
            if (spd_chg_req_o && !done_o) still++;
        end
        chk("R5 request held while busy reads 1", still, 20);
        spd_chg_busy_i = 1'b0;
        k = 0;
        while (spd_chg_req_o && k < 20) begin
            @(negedge clk);
            k++;
        end
        chk("R5 request dropped within one poll gap", int'(k >= 1 && k <= POLL_GAP), 1);
        repeat (5) @(negedge clk);
        chk("R7 waits for fresh link-up", int'(busy_o && !done_o), 1);
        cur_speed_i = 4'd2;
        link_up_i = 1'b1;
        run_until_end(cyc, rq, ov, bt);
        chk("R7 done after promotion", int'(done_o), 1);
        chk("R7 final speed gen2", int'(final_speed_o), 2);
        chk("R7 promotion flag clear", int'(gen2_off_o), 0);
    endtask

    task automatic t_skip_mode();
        int k;
        max_gen_i = 2'd2; sc_self_clear_i = 1'b0; link_up_i = 1'b1;
        spd_chg_busy_i = 1'b1; cur_speed_i = 4'd2;
        do_start();
        k = 0;
        while (!spd_chg_req_o && k < 10) begin
            @(negedge clk);
            k++;
        end
        chk("R6 request seen", int'(spd_chg_req_o), 1);
        @(negedge clk);
        chk("R6 request single cycle", int'(spd_chg_req_o), 0);
        chk("R6 not done yet", int'(done_o), 0);
        @(negedge clk);
        chk("R6 done straight after skip", int'(done_o), 1);
        chk("R7 final speed in skip mode", int'(final_speed_o), 2);
        spd_chg_busy_i = 1'b0;
    endtask

    task automatic t_poll_timeout();
        int cyc, rq, ov, bt;
        max_gen_i = 2'd2; sc_self_clear_i = 1'b1; link_up_i = 1'b1;
        spd_chg_busy_i = 1'b1; cur_speed_i = 4'd2;
        do_start();
        run_until_end(cyc, rq, ov, bt);
        chk("R5 poll timeout fails", int'(fail_o), 1);
        chk("R5 request length", rq, 1 + POLL_MAX * POLL_GAP);
        chk("R9 override hold length", ov, HOLD_CYC);
        chk("R9 training off during overrides", bt, 0);
        chk("R9 overrides released", int'(rx_data_en_ovr_o | rx_pll_en_ovr_o), 0);
        chk("R7 no final speed on failure", int'(final_speed_o), 0);
        repeat (8) @(negedge clk);
        chk("R10 fail held", int'(fail_o), 1);
        spd_chg_busy_i = 1'b0;
    endtask

    task automatic t_link_timeout(input int tmo);
        int cyc, rq, ov, bt;
        max_gen_i = 2'd1; link_up_i = 1'b0;
        link_tmo_i = TMO_W'(tmo);
        do_start();
        run_until_end(cyc, rq, ov, bt);
        chk("R8 link wait timeout fails", int'(fail_o), 1);
        chk("R8 fail timing", cyc, tmo + HOLD_CYC);
        chk("R9 hold after link timeout", ov, HOLD_CYC);
        link_tmo_i = TMO_W'(1000);
    endtask

    task automatic t_start_ignored();
        int cyc, rq, ov, bt, drop;
        max_gen_i = 2'd1; link_up_i = 1'b0; cur_speed_i = 4'd1;
        do_start();
        drop = 0;
        repeat (3) @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (3) begin
            if (!train_en_o) drop++;
            @(negedge clk);
        end
        link_up_i = 1'b1;
        run_until_end(cyc, rq, ov, bt);
        chk("R10 start while busy keeps training", drop, 0);
        chk("R10 start while busy run completes", int'(done_o), 1);
        chk("R10 completes on first link-up", cyc, 1);
        link_up_i = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_base_rate();
        t_self_clear();
        t_skip_mode();
        t_poll_timeout();
        t_link_timeout(50);
        t_link_timeout(10);
        t_start_ignored();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule